// File: doc/BRIEF.md
# Bus Cycle Acknowledge and Single-Step Controller

This block produces the active-low data transfer acknowledge for a 68000-family processor with an 8-bit data bus. It also derives a rough peripheral enable strobe from the processor's own bus strobes. In run mode the acknowledge is a direct copy of the address strobe. Every bus cycle therefore ends with zero wait states: four processor clocks per access, which at an 8 MHz processor clock gives an effective 2 MHz access rate.

In step mode the acknowledge is held back. The processor sits in its bus cycle until a step request arrives, so one request lets exactly one bus cycle finish. This is used to walk software through its bus traffic when debugging hardware. The step request comes from a slow source such as a push button. It passes through a two-flop synchroniser and edge detector, and each rising edge is worth one acknowledge.

The enable strobe is the NOR of the two active-low strobes. Its period follows the bus traffic, so it is not a fixed-frequency clock and must never serve as a timer time base. All inputs are taken as synchronous to `clk`.

Top module: `bus_ack_stepper`

## Requirements
- R1: With run mode in effect, `dtack_n` equals `as_n` in the same cycle, with no clock edge in between, so bus cycles take zero wait states.
- R2: `pseudo_e` is high exactly when both `as_n` and `ds_n` are low, and low otherwise.
- R3: With step mode in effect, `dtack_n` stays high throughout a bus cycle (`as_n` low) for which no step has been granted, however long that cycle lasts.
- R4: `step_req` passes through two synchronising flops and an edge detector. When `step_req` rises during a blocked cycle, `dtack_n` is still high after the second rising clock edge and goes low after the third.
- R5: A released acknowledge stays low until `as_n` goes high. `dtack_n` then rises in that same cycle, and the next bus cycle is blocked again until a further step.
- R6: A step edge seen while no bus cycle is active is held pending. When `as_n` next goes low, `dtack_n` goes low after one clock edge. That step then applies to that one cycle only.
- R7: A step edge seen while the acknowledge is already released is kept pending for the following cycle. Several such edges store only one step.
- R8: The `step_mode` input (1 = step, 0 = run) is sampled only on clock edges where `as_n` is high, so a mode change made during a bus cycle takes effect only after that cycle ends.
- R9: While `rst_n` is low, `dtack_n` is high whatever `as_n` is. Reset leaves run mode in effect and no step pending.
- R10: Step edges seen while run mode is in effect are discarded and do not carry over into a later step mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Synchronous active-low reset |
| as_n | input | 1 | Address strobe from the processor, active low |
| ds_n | input | 1 | Data strobe from the processor, active low |
| step_mode | input | 1 | Mode request: 1 = single-step, 0 = run |
| step_req | input | 1 | Asynchronous step request, one step per rising edge |
| dtack_n | output | 1 | Data transfer acknowledge to the processor, active low |
| pseudo_e | output | 1 | Peripheral enable strobe, NOR of the two strobes |

## Verification
On every cycle, the assertions check the following:
- In effective run mode, an active address strobe always meets an asserted acknowledge.
- No acknowledge is driven outside a bus cycle.
- The effective mode cannot move while a cycle is open.
- A released acknowledge holds until the strobe is dropped.
- Each release is backed by a pending step or a fresh edge.
- Run mode never keeps a pending step.
- The edge detector never fires on two cycles in a row.

Only the bench scenarios can show the rest:
- The exact three-edge latency from a step request to the acknowledge.
- That one step request opens only one cycle.
- That several edges during a released cycle store only one step.
- That steps given in run mode are lost once step mode begins.

// File: rtl/bus_step_pkg.sv
// Package: shared types for the bus acknowledge / single-step controller.
// Assumes all users agree on the two-valued operating mode below.
package bus_step_pkg;

    // Effective operating mode of the acknowledge path.
    typedef enum logic {
        MODE_RUN  = 1'b0,
        MODE_STEP = 1'b1
    } bus_mode_t;

endpackage

// File: rtl/step_sync.sv
// Module: step_sync
// Brings the asynchronous step request into the clk domain through a
// parameterised chain of flops, then emits a one-cycle pulse on each
// rising edge of the synchronised level.
// Assumes the request stays high and low for at least two clk cycles each.
module step_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_async,
    output logic req_edge
);

    localparam int LAST = SYNC_STAGES - 1;

    logic [LAST:0] chain_q;
    logic          prev_q;

    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // Purpose: first capture flop for the asynchronous request.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= req_async;
                end
            end else begin : g_next
                // Purpose: further metastability settling stage.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    // Purpose: remember last synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[LAST];
    end

    // Purpose: rising-edge pulse of the synchronised request.
    always_comb begin
        req_edge = chain_q[LAST] & ~prev_q;
    end

    AST_EDGE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_edge |=> !req_edge); // R4

endmodule

// File: rtl/step_gate.sv
// Module: step_gate
// Holds the effective mode, the pending-step flag and the release flag
// that lets one bus cycle finish in step mode.
// Assumes as_n is synchronous to clk. A cycle is open while as_n is low.
module step_gate
    import bus_step_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      as_n,
    input  logic      mode_req,
    input  logic      step_edge,
    output bus_mode_t mode_q,
    output logic      released_q
);

    logic pending_q;
    logic grant;

    // Purpose: decide whether a step may release the open bus cycle now.
    always_comb begin
        grant = (mode_q == MODE_STEP) && !as_n && !released_q
                && (pending_q || step_edge);
    end

    // Purpose: sample the requested mode only between bus cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)    mode_q <= MODE_RUN;
        else if (as_n) mode_q <= mode_req ? MODE_STEP : MODE_RUN;
    end

    // Purpose: set release on a grant, clear it when the strobe drops.
    always_ff @(posedge clk) begin
        if (!rst_n)     released_q <= 1'b0;
        else if (as_n)  released_q <= 1'b0;
        else if (grant) released_q <= 1'b1;
    end

    // Purpose: keep one step for a later cycle; discard in run mode.
    always_ff @(posedge clk) begin
        if (!rst_n)                  pending_q <= 1'b0;
        else if (mode_q == MODE_RUN) pending_q <= 1'b0;
        else if (grant)              pending_q <= 1'b0;
        else if (step_edge)          pending_q <= 1'b1;
    end

    AST_RELEASE_NEEDS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(released_q) |-> $past(pending_q || step_edge)); // R6

    AST_RELEASE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (released_q && !as_n) |=> released_q); // R5

    AST_MODE_FROZEN_IN_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        !as_n |=> $stable(mode_q)); // R8

    AST_RUN_DROPS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_RUN) |=> !pending_q); // R10

endmodule

// File: rtl/strobe_decode.sv
// Module: strobe_decode
// Combinational output stage. It picks the acknowledge source for the
// effective mode and forms the pseudo enable strobe as a NOR of the strobes.
// Assumes the caller holds rst_n low to force the acknowledge off.
module strobe_decode
    import bus_step_pkg::*;
(
    input  logic      rst_n,
    input  logic      as_n,
    input  logic      ds_n,
    input  bus_mode_t mode,
    input  logic      released,
    output logic      dtack_n,
    output logic      pseudo_e
);

    // Purpose: zero-wait acknowledge in run mode, gated one in step mode.
    always_comb begin
        if (!rst_n)                dtack_n = 1'b1;
        else if (mode == MODE_RUN) dtack_n = as_n;
        else                       dtack_n = as_n | ~released;
    end

    // Purpose: rough enable, high only while both strobes are asserted.
    always_comb begin
        pseudo_e = ~(as_n | ds_n);
    end

endmodule

// File: rtl/bus_ack_stepper.sv
// Module: bus_ack_stepper (top)
// Acknowledge generator with an optional single-step gate for a
// 68000-family bus, plus a pseudo enable strobe built from the strobes.
// Assumes as_n, ds_n and step_mode are synchronous to clk, and step_req
// is asynchronous and slow.
module bus_ack_stepper
    import bus_step_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic as_n,
    input  logic ds_n,
    input  logic step_mode,
    input  logic step_req,
    output logic dtack_n,
    output logic pseudo_e
);

    logic      step_edge;
    bus_mode_t mode_eff;
    logic      released;

    step_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_async(step_req),
        .req_edge (step_edge)
    );

    step_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .as_n      (as_n),
        .mode_req  (step_mode),
        .step_edge (step_edge),
        .mode_q    (mode_eff),
        .released_q(released)
    );

    strobe_decode u_dec (
        .rst_n   (rst_n),
        .as_n    (as_n),
        .ds_n    (ds_n),
        .mode    (mode_eff),
        .released(released),
        .dtack_n (dtack_n),
        .pseudo_e(pseudo_e)
    );

    AST_RUN_ZERO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_eff == MODE_RUN && !as_n) |-> !dtack_n); // R1

    AST_NO_ACK_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        as_n |-> dtack_n); // R5

    AST_ENABLE_NEEDS_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
        pseudo_e |-> (!as_n && !ds_n)); // R2

endmodule

// File: tb/tb_bus_ack_stepper.sv
module tb_bus_ack_stepper;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic as_n = 1'b1;
    logic ds_n = 1'b1;
    logic step_mode = 1'b0;
    logic step_req = 1'b0;
    logic dtack_n;
    logic pseudo_e;

    int n_tests = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    bus_ack_stepper dut (
        .clk(clk), .rst_n(rst_n), .as_n(as_n), .ds_n(ds_n),
        .step_mode(step_mode), .step_req(step_req),
        .dtack_n(dtack_n), .pseudo_e(pseudo_e)
    );

    task automatic check(input logic act, input logic exp, input string req);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // Let n rising edges pass, then settle just after the falling edge.
    task automatic edges(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
        #0.5;
    endtask

    // Drive at the falling edge, then sample after the combinational path.
    task automatic drive_as(input logic v);
        @(negedge clk);
        as_n = v;
        #0.5;
    endtask

    task automatic pulse_step();
        @(negedge clk); step_req = 1'b1;
        edges(3);
        step_req = 1'b0;
        edges(3);
    endtask

    task automatic t_reset();
        as_n = 1'b0; step_mode = 1'b1;
        edges(2);
        check(dtack_n, 1'b1, "R9 ack off in reset");
        @(negedge clk); rst_n = 1'b1; #0.5;
        check(dtack_n, 1'b0, "R9 run mode after reset");
        edges(3);
        check(dtack_n, 1'b0, "R8 mode held during open cycle");
        drive_as(1'b1);
        check(dtack_n, 1'b1, "R5 ack drops with strobe");
        edges(1);
    endtask

    task automatic t_run();
        step_mode = 1'b0;
        edges(1);
        drive_as(1'b0);
        check(dtack_n, 1'b0, "R1 zero wait ack");
        drive_as(1'b1);
        check(dtack_n, 1'b1, "R1 ack follows strobe high");
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            as_n = k[0]; ds_n = k[1];
            #0.5;
            check(pseudo_e, (k == 0), "R2 pseudo enable NOR");
        end
        as_n = 1'b1; ds_n = 1'b1;
        edges(1);
    endtask

    task automatic t_step_basic();
        step_mode = 1'b1;
        edges(2);
        drive_as(1'b0);
        edges(5);
        check(dtack_n, 1'b1, "R3 blocked without step");
        step_req = 1'b1;
        edges(2);
        check(dtack_n, 1'b1, "R4 still blocked after two edges");
        edges(1);
        check(dtack_n, 1'b0, "R4 released after third edge");
        step_req = 1'b0;
        edges(4);
        check(dtack_n, 1'b0, "R5 release holds");
        drive_as(1'b1);
        check(dtack_n, 1'b1, "R5 ack rises with strobe");
        edges(1);
        drive_as(1'b0);
        edges(5);
        check(dtack_n, 1'b1, "R5 next cycle blocked again");
        drive_as(1'b1);
        edges(1);
    endtask

    task automatic t_pending();
        pulse_step();
        check(dtack_n, 1'b1, "R6 no ack while idle");
        drive_as(1'b0);
        check(dtack_n, 1'b1, "R6 not before a clock edge");
        edges(1);
        check(dtack_n, 1'b0, "R6 pending step releases");
        drive_as(1'b1);
        edges(1);
        drive_as(1'b0);
        edges(5);
        check(dtack_n, 1'b1, "R6 one step one cycle");
        drive_as(1'b1);
        edges(1);
    endtask

    task automatic t_extra_steps();
        pulse_step();
        drive_as(1'b0);
        edges(1);
        check(dtack_n, 1'b0, "R7 first cycle released");
        pulse_step();
        pulse_step();
        drive_as(1'b1);
        edges(1);
        drive_as(1'b0);
        edges(1);
        check(dtack_n, 1'b0, "R7 kept step releases next cycle");
        drive_as(1'b1);
        edges(1);
        drive_as(1'b0);
        edges(5);
        check(dtack_n, 1'b1, "R7 steps do not stack");
        drive_as(1'b1);
        edges(1);
    endtask

    task automatic t_mode_change();
        drive_as(1'b0);
        step_mode = 1'b0;
        edges(3);
        check(dtack_n, 1'b1, "R8 run request waits for cycle end");
        drive_as(1'b1);
        edges(1);
        drive_as(1'b0);
        check(dtack_n, 1'b0, "R8 run in effect next cycle");
        step_mode = 1'b1;
        edges(2);
        check(dtack_n, 1'b0, "R8 step request waits for cycle end");
        drive_as(1'b1);
        edges(1);
        drive_as(1'b0);
        edges(3);
        check(dtack_n, 1'b1, "R8 step in effect next cycle");
        drive_as(1'b1);
        edges(1);
    endtask

    task automatic t_run_ignore();
        step_mode = 1'b0;
        edges(2);
        pulse_step();
        step_mode = 1'b1;
        edges(2);
        drive_as(1'b0);
        edges(5);
        check(dtack_n, 1'b1, "R10 run-mode step discarded");
        drive_as(1'b1);
        edges(1);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_run();
                t_step_basic();
                t_pending();
                t_extra_steps();
                t_mode_change();
                t_run_ignore();
            end
            begin
                repeat (20000) @(posedge clk);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule